// File: doc/BRIEF.md
# Retriggerable Mute One-Shot Timer

This block makes a muting pulse of roughly 300 ms whenever a tuning controller loads a new control word that asks for it. The pulse length is counted in periods of a slow 50 Hz square wave that comes in as an input. Each rising edge of that square wave is one tick, and the default pulse is 15 ticks long. A trigger comes from the word-latch strobe of the serial control port. It counts only when the timer-request bit of that word is high and both operating-mode bits are low, which is the normal mode.

While a pulse runs, the third status output carries the inverse of the resting level. The resting level is the latched static status bit as it stood when the pulse was armed. When no pulse runs, the output simply follows the latched static status bit. A new high request during a pulse restarts the full count. A low request during a pulse leaves it alone. Reset starts a pulse of its own, so the output sits in the muted level for one full period after power-up.

Top module: `muteOneShot`

## Requirements
- R1: After reset the output is high (muted) for exactly PULSE_TICKS ticks, whatever the status bit is. It then follows the status bit.
- R2: A latch strobe with the request bit high and mode bits 2'b00 drives the output, on the next clock, to the inverse of the status bit at that strobe.
- R3: A pulse armed from idle ends on the PULSE_TICKS-th tick after arming. It never holds more than PULSE_TICKS ticks.
- R4: A latch strobe with the request bit low during a pulse does not shorten the pulse.
- R5: A latch strobe with a high request bit during a pulse reloads a full PULSE_TICKS ticks from that strobe.
- R6: When the mode bits are not 2'b00, a high request does not arm the timer, and the output follows the status bit.
- R7: With no pulse running, the output equals the status bit in the same cycle.
- R8: A tick is counted only on the low-to-high transition of the timebase input. A level held high counts once.
- R9: When a trigger and a tick arrive in the same clock, the reload wins and that tick is not counted.
- R10: The pulse level is fixed at arming. A change of the status bit during a pulse does not move the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, starts the power-up pulse |
| tick50 | input | 1 | 50 Hz timebase square wave, counted on its rising edge |
| latchEvt | input | 1 | One-cycle strobe when a serial control word is latched |
| reqBit | input | 1 | Timer-request bit of the latched word |
| modeBits | input | 2 | Operating-mode bits of the latched word, 2'b00 is normal |
| statusBit | input | 1 | Latched static status bit for the third output |
| muteOut | output | 1 | Third status output: pulse or status bit |

## Verification
A wrong count value shows at the output as a pulse that ends one or more ticks too early or too late. So each scenario counts ticks up to the expected end and checks the output one tick before it and on it. A lost captured level shows at once as an output that moves with the status bit during a pulse. A wrongly gated arm shows on the clock after the strobe, either as a pulse in a test mode or as a missing pulse in normal mode. Edge-detection faults show as a pulse that is too short when the timebase stays high for many clocks.

// File: rtl/muteTimerPkg.sv
package muteTimerPkg;
  localparam logic [1:0] MODE_NORMAL = 2'b00;

  typedef struct packed {
    logic load;      // reload the tick counter with a full period
    logic dec;       // take one tick off the counter
    logic takeLvl;   // capture the pulse level from the status bit
    logic showPulse; // route the pulse level to the output
  } muteStrobe_t;
endpackage

// File: rtl/muteTickEdge.sv
module muteTickEdge #(
  parameter bit TICK_IS_STROBE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  output logic tickRise
);
  generate
    if (TICK_IS_STROBE) begin : g_strobe
      assign tickRise = tickIn;
    end else begin : g_edge
      logic tickPrev;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tickPrev <= 1'b0;
        else       tickPrev <= tickIn;
      end
      assign tickRise = tickIn & ~tickPrev;
    end
  endgenerate
endmodule

// File: rtl/muteTimerCtrl.sv
module muteTimerCtrl
  import muteTimerPkg::*;
(
  input  logic        latchEvt,
  input  logic        reqBit,
  input  logic [1:0]  modeBits,
  input  logic        tickRise,
  input  logic        running,
  output muteStrobe_t strobe
);
  logic modeNormal;
  logic arm;

  always_comb begin
    modeNormal       = (modeBits == MODE_NORMAL);
    arm              = latchEvt & reqBit & modeNormal;
    strobe.load      = arm;
    strobe.dec       = tickRise & running & ~arm;
    strobe.takeLvl   = arm & ~running;
    strobe.showPulse = running & modeNormal;
  end
endmodule

// File: rtl/muteTimerDp.sv
module muteTimerDp
  import muteTimerPkg::*;
#(
  parameter int PULSE_TICKS = 15,
  localparam int CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  muteStrobe_t   strobe,
  input  logic          statusBit,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic          muteOut
);
  localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

  logic pulseLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= FULL;
      pulseLvl <= 1'b1;
    end else begin
      if (strobe.load)      cnt <= FULL;
      else if (strobe.dec)  cnt <= cnt - 1'b1;
      if (strobe.takeLvl)   pulseLvl <= ~statusBit;
    end
  end

  assign running = (cnt != '0);
  assign muteOut = strobe.showPulse ? pulseLvl : statusBit;
endmodule

// File: rtl/muteOneShot.sv
module muteOneShot
  import muteTimerPkg::*;
#(
  parameter int PULSE_TICKS    = 15,
  parameter bit TICK_IS_STROBE = 1'b0,
  localparam int CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick50,
  input  logic       latchEvt,
  input  logic       reqBit,
  input  logic [1:0] modeBits,
  input  logic       statusBit,
  output logic       muteOut
);
  logic          tickRise;
  logic          running;
  logic [CW-1:0] cnt;
  muteStrobe_t   strobe;

  muteTickEdge #(.TICK_IS_STROBE(TICK_IS_STROBE)) u_edge (
    .clk(clk), .rstN(rstN), .tickIn(tick50), .tickRise(tickRise)
  );

  muteTimerCtrl u_ctrl (
    .latchEvt(latchEvt), .reqBit(reqBit), .modeBits(modeBits),
    .tickRise(tickRise), .running(running), .strobe(strobe)
  );

  muteTimerDp #(.PULSE_TICKS(PULSE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusBit(statusBit),
    .running(running), .cnt(cnt), .muteOut(muteOut)
  );
endmodule

// File: rtl/muteOneShotChk.sv
module muteOneShotChk #(
  parameter int PERIOD = 15,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          latchEvt,
  input logic          reqBit,
  input logic [1:0]    modeBits,
  input logic          statusBit,
  input logic          tickRise,
  input logic [CW-1:0] cnt,
  input logic          muteOut
);
  // R2 / R5: a normal-mode high request sets a full period
  a_r2_arm_full: assert property (@(posedge clk) disable iff (!rstN)
    (latchEvt && reqBit && modeBits == 2'b00) |=> (cnt == CW'(PERIOD)));

  // R3: counter bounded by one period
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(PERIOD));

  // R3: a tick without a trigger takes exactly one off a running count
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && tickRise && !(latchEvt && reqBit && modeBits == 2'b00))
      |=> (cnt == $past(cnt) - 1'b1));

  // R4: low request leaves a running count alone
  a_r4_low_req_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && latchEvt && !reqBit && !tickRise) |=> (cnt == $past(cnt)));

  // R6: test modes pass the status bit through
  a_r6_test_mode_pass: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits != 2'b00) |-> (muteOut == statusBit));

  // R7: idle output follows the status bit
  a_r7_idle_follow: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> (muteOut == statusBit));

  // R10: output steady through a pulse in normal mode
  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && $past(cnt) != '0 && modeBits == 2'b00 && $past(modeBits) == 2'b00)
      |-> $stable(muteOut));
endmodule

bind muteOneShot muteOneShotChk #(.PERIOD(PULSE_TICKS)) u_chk (
  .clk(clk), .rstN(rstN), .latchEvt(latchEvt), .reqBit(reqBit),
  .modeBits(modeBits), .statusBit(statusBit), .tickRise(tickRise),
  .cnt(cnt), .muteOut(muteOut)
);

// File: tb/tb_muteOneShot.sv
`timescale 1ns/1ps
module tb_muteOneShot;
  localparam int TICKS = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick50 = 1'b0;
  logic       latchEvt = 1'b0;
  logic       reqBit = 1'b0;
  logic [1:0] modeBits = 2'b00;
  logic       statusBit = 1'b0;
  logic       muteOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  muteOneShot #(.PULSE_TICKS(TICKS)) dut (
    .clk(clk), .rstN(rstN), .tick50(tick50), .latchEvt(latchEvt),
    .reqBit(reqBit), .modeBits(modeBits), .statusBit(statusBit),
    .muteOut(muteOut)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (muteOut !== exp) begin
      fails++;
      $display("FAIL %s: muteOut=%b expected=%b at %0t", req, muteOut, exp, $time);
    end
  endtask

  task automatic tickOnce(input int highCycles = 1);
    @(negedge clk) tick50 = 1'b1;
    repeat (highCycles) @(negedge clk);
    tick50 = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tickOnce();
  endtask

  task automatic latchWord(input logic req, input logic [1:0] mode);
    @(negedge clk);
    latchEvt = 1'b1; reqBit = req; modeBits = mode;
    @(negedge clk);
    latchEvt = 1'b0; reqBit = 1'b0;
  endtask

  task automatic testReset();
    statusBit = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 power-up muted", 1'b1);
    ticks(TICKS - 1);
    chk("R1 muted before last tick", 1'b1);
    ticks(1);
    chk("R1 released after full period", 1'b0);
  endtask

  task automatic testIdle();
    @(negedge clk) statusBit = 1'b1;
    #1 chk("R7 idle follows status high", 1'b1);
    @(negedge clk) statusBit = 1'b0;
    #1 chk("R7 idle follows status low", 1'b0);
  endtask

  task automatic testArmLength();
    statusBit = 1'b0;
    latchWord(1'b1, 2'b00);
    chk("R2 armed inverts status", 1'b1);
    ticks(TICKS - 1);
    chk("R3 still muted one tick early", 1'b1);
    ticks(1);
    chk("R3 ends on last tick", 1'b0);
  endtask

  task automatic testLevelHold();
    statusBit = 1'b1;
    latchWord(1'b1, 2'b00);
    chk("R2 armed from high status", 1'b0);
    @(negedge clk) statusBit = 1'b0;
    #1 chk("R10 level held when status falls", 1'b0);
    ticks(3);
    @(negedge clk) statusBit = 1'b1;
    #1 chk("R10 level held when status rises", 1'b0);
    ticks(TICKS - 3);
    chk("R10 status shows after end", 1'b1);
    statusBit = 1'b0;
  endtask

  task automatic testLowReq();
    latchWord(1'b1, 2'b00);
    ticks(10);
    latchWord(1'b0, 2'b00);
    chk("R4 low request keeps pulse", 1'b1);
    ticks(TICKS - 11);
    chk("R4 pulse not shortened", 1'b1);
    ticks(1);
    chk("R4 pulse ends on schedule", 1'b0);
  endtask

  task automatic testRetrigger();
    latchWord(1'b1, 2'b00);
    ticks(10);
    latchWord(1'b1, 2'b00);
    ticks(TICKS - 1);
    chk("R5 extended beyond first period", 1'b1);
    ticks(1);
    chk("R5 extension ends after full reload", 1'b0);
  endtask

  task automatic testModeGate();
    statusBit = 1'b0;
    latchWord(1'b1, 2'b01);
    chk("R6 test mode does not arm", 1'b0);
    @(negedge clk) modeBits = 2'b00;
    #1 chk("R6 no pulse after return to normal", 1'b0);
    latchWord(1'b1, 2'b00);
    @(negedge clk) modeBits = 2'b10;
    #1 chk("R6 test mode shows status during pulse", 1'b0);
    @(negedge clk) modeBits = 2'b00;
    #1 chk("R6 pulse visible again in normal", 1'b1);
    ticks(TICKS);
    chk("R6 pulse over", 1'b0);
  endtask

  task automatic testLongTick();
    latchWord(1'b1, 2'b00);
    tickOnce(10);
    ticks(TICKS - 2);
    chk("R8 long high level counted once", 1'b1);
    ticks(1);
    chk("R8 ends after full count", 1'b0);
  endtask

  task automatic testTieTick();
    latchWord(1'b1, 2'b00);
    ticks(10);
    @(negedge clk);
    tick50 = 1'b1; latchEvt = 1'b1; reqBit = 1'b1; modeBits = 2'b00;
    @(negedge clk);
    latchEvt = 1'b0; reqBit = 1'b0; tick50 = 1'b0;
    @(negedge clk);
    ticks(TICKS - 1);
    chk("R9 reload wins over tick", 1'b1);
    ticks(1);
    chk("R9 ends after full period", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testIdle();
    testArmLength();
    testLevelHold();
    testLowReq();
    testRetrigger();
    testModeGate();
    testLongTick();
    testTieTick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule